// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block works out how a processor core enters a handler when an exception or a hardware interrupt is pending. The core presents its status word, program counter, stack register and vector base on every cycle, together with the pending exception code, the interrupt request, the sleep state and a delay-slot flag. The block sends the current interrupt mask level to the interrupt controller. The controller answers in the same cycle with either a vector or "none".

The core pulses `take_event` when it is at a boundary where an event may be accepted. On that clock edge the block settles which event wins and applies the masking rules. When an event is accepted, it captures the saved status, saved PC and saved stack pointer, and records the event code. It then presents the new status word and the handler address. All of this happens in one clock edge. The `taken` output is high for one cycle afterwards. While `taken` is high the core loads `sr_out` and `pc_out`, clears its delay-slot flags and leaves sleep.

Top module: `exc_entry_seq`

## Requirements
- R1: After a synchronous reset every register output is zero and `taken` is low.
- R2: When `exc_valid` and an interrupt are both pending, the exception is taken and `intevt_out` keeps its previous value.
- R3: While the block bit (`sr_in[28]`) is set, a pending exception whose code is not 0x1E0 is recorded and handled as code 0x000. Code 0x1E0 keeps its own code.
- R4: While the block bit is set and the core is not sleeping, an interrupt request with no pending exception changes no output and leaves `taken` low. When the core is sleeping, the interrupt is processed normally.
- R5: On any accepted event, `ssr_out` receives `sr_in` and `sgr_out` receives `r15_in`. `sr_out` is `sr_in` with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R6: When `dslot_in` is high on an accepted event, `spc_out` is `pc_in - 2`. Otherwise, apart from R9, it is `pc_in`.
- R7: Exception codes 0x000, 0x020 and 0x140 clear `sr_out[15]` (FPU disable), set `sr_out[7:4]` to 0xF and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to `vbr_in + 0x400`. Any other exception not covered by R7 jumps to `vbr_in + 0x100`. The effective exception code is written to `expevt_out`.
- R9: For exception code 0x160, `spc_out` is increased by 2, on top of any delay-slot rewind.
- R10: `irq_level` always equals `sr_in[7:4]`. An interrupt with `irq_vec_valid` low changes nothing. With `irq_vec_valid` high, `intevt_out` receives `irq_vec`, `pc_out` becomes `vbr_in + 0x600`, and `expevt_out` is unchanged.
- R11: With `take_event` low no output changes. `taken` is high for exactly the one cycle after an accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| take_event | input | 1 | Core is at an event-accept boundary |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | Hardware interrupt request |
| core_sleep | input | 1 | Core is in sleep state |
| dslot_in | input | 1 | Current instruction sits in a branch delay slot |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base |
| irq_level | output | 4 | Mask level sent to the interrupt controller |
| irq_vec_valid | input | 1 | Controller has a vector above the mask level |
| irq_vec | input | 12 | Vector from the controller |
| taken | output | 1 | One-cycle pulse after an accepted event |
| sr_out | output | 32 | New status word |
| pc_out | output | 32 | Handler address |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved program counter |
| sgr_out | output | 32 | Saved stack register |
| expevt_out | output | 12 | Last exception code |
| intevt_out | output | 12 | Last interrupt vector |

## Verification
The bench aims at the points where the masking rules meet. With the block bit set, code 0x1E0 must not be turned into a reset; a design that converts it would show 0x000 in `expevt_out` and jump to the fixed reset address. An interrupt arriving during a sleep with the block bit set must still be taken; a design that ignores the sleep exemption would leave `taken` low. A trap in a delay slot must give back exactly `pc_in`; a design that applies only one of the two adjustments is off by two. An interrupt with no vector must leave every saved register alone; a design that saves state before checking for a vector would overwrite `ssr_out`.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_EXC = 2'd1, EV_IRQ = 2'd2} ev_kind_t;

  // status word bit positions the core decodes
  localparam int SR_PRIV_BIT  = 30;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_BLOCK_BIT = 28;
  localparam int SR_FPD_BIT   = 15;
  localparam int SR_MASK_LO   = 4;
  localparam int SR_MASK_W    = 4;

  localparam logic [CODE_W-1:0] C_POWERON  = 12'h000;
  localparam logic [CODE_W-1:0] C_MANUAL   = 12'h020;
  localparam logic [CODE_W-1:0] C_MULTIHIT = 12'h140;
  localparam logic [CODE_W-1:0] C_MISS_RD  = 12'h040;
  localparam logic [CODE_W-1:0] C_MISS_WR  = 12'h060;
  localparam logic [CODE_W-1:0] C_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] C_UNMASKED = 12'h1E0;

  function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
    return (c == C_POWERON) || (c == C_MANUAL) || (c == C_MULTIHIT);
  endfunction

  function automatic logic is_miss_class(input logic [CODE_W-1:0] c);
    return (c == C_MISS_RD) || (c == C_MISS_WR);
  endfunction
endpackage

// File: rtl/evt_select.sv
module evt_select
  import evt_pkg::*;
(
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              core_sleep,
  input  logic              block_bit,
  input  logic              irq_vec_valid,
  input  logic [CODE_W-1:0] irq_vec,
  output ev_kind_t          kind,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    kind = EV_NONE;
    code = '0;
    if (exc_valid) begin
      kind = EV_EXC;
      // a blocked exception degrades to a reset, one code is exempt
      code = (block_bit && exc_code != C_UNMASKED) ? C_POWERON : exc_code;
    end else if (irq_req && (!block_bit || core_sleep) && irq_vec_valid) begin
      kind = EV_IRQ;
      code = irq_vec;
    end
  end
endmodule

// File: rtl/evt_target.sv
module evt_target
  import evt_pkg::*;
#(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC  = 32'hA000_0000,
  parameter logic [AW-1:0] OFS_GEN   = 32'h0000_0100,
  parameter logic [AW-1:0] OFS_MISS  = 32'h0000_0400,
  parameter logic [AW-1:0] OFS_IRQ   = 32'h0000_0600,
  parameter int            INSN_B    = 2
) (
  input  ev_kind_t          kind,
  input  logic [CODE_W-1:0] code,
  input  logic [31:0]       sr_in,
  input  logic [AW-1:0]     pc_in,
  input  logic [AW-1:0]     vbr_in,
  input  logic              dslot_in,
  output logic [31:0]       sr_next,
  output logic [AW-1:0]     spc_next,
  output logic [AW-1:0]     pc_next
);
  localparam logic [AW-1:0] STEP = AW'(INSN_B);

  logic [AW-1:0] rewind, advance;

  always_comb begin
    sr_next = sr_in;
    sr_next[SR_PRIV_BIT]  = 1'b1;
    sr_next[SR_BANK_BIT]  = 1'b1;
    sr_next[SR_BLOCK_BIT] = 1'b1;
    pc_next = vbr_in + OFS_IRQ;
    if (kind == EV_EXC) begin
      if (is_reset_class(code)) begin
        sr_next[SR_FPD_BIT] = 1'b0;
        sr_next[SR_MASK_LO +: SR_MASK_W] = '1;
        pc_next = RESET_PC;
      end else if (is_miss_class(code)) begin
        pc_next = vbr_in + OFS_MISS;
      end else begin
        pc_next = vbr_in + OFS_GEN;
      end
    end
  end

  assign rewind   = dslot_in ? STEP : '0;
  assign advance  = (kind == EV_EXC && code == C_TRAP) ? STEP : '0;
  assign spc_next = pc_in - rewind + advance;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import evt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_event,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              core_sleep,
  input  logic              dslot_in,
  input  logic [31:0]       sr_in,
  input  logic [AW-1:0]     pc_in,
  input  logic [31:0]       r15_in,
  input  logic [AW-1:0]     vbr_in,
  output logic [SR_MASK_W-1:0] irq_level,
  input  logic              irq_vec_valid,
  input  logic [CODE_W-1:0] irq_vec,
  output logic              taken,
  output logic [31:0]       sr_out,
  output logic [AW-1:0]     pc_out,
  output logic [31:0]       ssr_out,
  output logic [AW-1:0]     spc_out,
  output logic [31:0]       sgr_out,
  output logic [CODE_W-1:0] expevt_out,
  output logic [CODE_W-1:0] intevt_out
);
  ev_kind_t          kind;
  logic [CODE_W-1:0] code;
  logic [31:0]       sr_next;
  logic [AW-1:0]     spc_next, pc_next;
  logic              accept;

  assign irq_level = sr_in[SR_MASK_LO +: SR_MASK_W];

  evt_select u_sel (
    .exc_valid     (exc_valid),
    .exc_code      (exc_code),
    .irq_req       (irq_req),
    .core_sleep    (core_sleep),
    .block_bit     (sr_in[SR_BLOCK_BIT]),
    .irq_vec_valid (irq_vec_valid),
    .irq_vec       (irq_vec),
    .kind          (kind),
    .code          (code)
  );

  evt_target #(.AW(AW)) u_tgt (
    .kind     (kind),
    .code     (code),
    .sr_in    (sr_in),
    .pc_in    (pc_in),
    .vbr_in   (vbr_in),
    .dslot_in (dslot_in),
    .sr_next  (sr_next),
    .spc_next (spc_next),
    .pc_next  (pc_next)
  );

  assign accept = take_event && (kind != EV_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      taken      <= 1'b0;
      sr_out     <= '0;
      pc_out     <= '0;
      ssr_out    <= '0;
      spc_out    <= '0;
      sgr_out    <= '0;
      expevt_out <= '0;
      intevt_out <= '0;
    end else begin
      taken <= accept;
      if (accept) begin
        sr_out  <= sr_next;
        pc_out  <= pc_next;
        ssr_out <= sr_in;
        spc_out <= spc_next;
        sgr_out <= r15_in;
        if (kind == EV_EXC) expevt_out <= code;
        else                intevt_out <= code;
      end
    end
  end

  // R11
  taken_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    taken |-> $past(take_event));
  // R11
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !taken |-> ($stable(ssr_out) && $stable(spc_out) && $stable(pc_out)));
  // R5
  entry_bits_chk: assert property (@(posedge clk) disable iff (rst)
    taken |-> (sr_out[SR_PRIV_BIT] && sr_out[SR_BANK_BIT] && sr_out[SR_BLOCK_BIT]));
  // R2
  exc_keeps_intevt_chk: assert property (@(posedge clk) disable iff (rst)
    (taken && $past(exc_valid)) |-> $stable(intevt_out));
  // R10
  irq_needs_vector_chk: assert property (@(posedge clk) disable iff (rst)
    taken |-> ($past(exc_valid) || $past(irq_vec_valid)));
  // R4
  blocked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (take_event && !exc_valid && sr_in[SR_BLOCK_BIT] && !core_sleep) |=> !taken);
endmodule

// File: tb/test_exc_entry_seq.sv
`timescale 1ns/1ps
module test_exc_entry_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        take_event, exc_valid, irq_req, core_sleep, dslot_in, irq_vec_valid;
  logic [11:0] exc_code, irq_vec;
  logic [31:0] sr_in, pc_in, r15_in, vbr_in;
  logic [3:0]  irq_level;
  logic        taken;
  logic [31:0] sr_out, pc_out, ssr_out, spc_out, sgr_out;
  logic [11:0] expevt_out, intevt_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_sr, m_pc, m_ssr, m_spc, m_sgr;
  logic [11:0] m_exp, m_int;

  always #2.5 clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst), .take_event(take_event), .exc_valid(exc_valid),
    .exc_code(exc_code), .irq_req(irq_req), .core_sleep(core_sleep),
    .dslot_in(dslot_in), .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in),
    .vbr_in(vbr_in), .irq_level(irq_level), .irq_vec_valid(irq_vec_valid),
    .irq_vec(irq_vec), .taken(taken), .sr_out(sr_out), .pc_out(pc_out),
    .ssr_out(ssr_out), .spc_out(spc_out), .sgr_out(sgr_out),
    .expevt_out(expevt_out), .intevt_out(intevt_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] pick_code(input int unsigned n);
    case (n % 14)
      0: return 12'h000;  1: return 12'h020;  2: return 12'h040;
      3: return 12'h060;  4: return 12'h080;  5: return 12'h0A0;
      6: return 12'h0C0;  7: return 12'h0E0;  8: return 12'h100;
      9: return 12'h140; 10: return 12'h160; 11: return 12'h180;
      12: return 12'h1E0; default: return 12'h800;
    endcase
  endfunction

  // drive one cycle of inputs at a falling edge, predict, check at the next falling edge
  task automatic step(input logic te, input logic ev, input logic [11:0] ec,
                      input logic ir, input logic sl, input logic ds,
                      input logic [31:0] sr, input logic [31:0] pc,
                      input logic [31:0] r15, input logic [31:0] vbr,
                      input logic vv, input logic [11:0] vec);
    logic bl, acc, isexc, rcls, trap;
    logic [11:0] c;
    logic [31:0] nsr;
    string rpc, rspc, rsr, rexp, rint;
    take_event = te; exc_valid = ev; exc_code = ec; irq_req = ir;
    core_sleep = sl; dslot_in = ds; sr_in = sr; pc_in = pc; r15_in = r15;
    vbr_in = vbr; irq_vec_valid = vv; irq_vec = vec;
    #1;
    check("R10", "irq_level", {28'd0, irq_level}, {28'd0, sr[7:4]});
    bl = sr[28];
    isexc = ev;
    c = ev ? ((bl && ec != 12'h1E0) ? 12'h000 : ec) : vec;
    acc = te && (ev || (ir && (!bl || sl) && vv));
    rcls = isexc && (c == 12'h000 || c == 12'h020 || c == 12'h140);
    trap = isexc && (c == 12'h160);
    rpc = "R8"; rspc = "R5"; rsr = "R5"; rexp = "R8"; rint = "R10";
    if (acc) begin
      nsr = sr | 32'h7000_0000;
      if (rcls) begin nsr[15] = 1'b0; nsr[7:4] = 4'hF; rsr = "R7"; end
      m_ssr = sr; m_sgr = r15; m_sr = nsr;
      m_spc = pc - (ds ? 32'd2 : 32'd0) + (trap ? 32'd2 : 32'd0);
      if (trap) rspc = "R9"; else if (ds) rspc = "R6";
      if (!isexc) m_pc = vbr + 32'h600;
      else if (rcls) begin m_pc = 32'hA000_0000; rpc = "R7"; end
      else if (c == 12'h040 || c == 12'h060) m_pc = vbr + 32'h400;
      else m_pc = vbr + 32'h100;
      if (isexc) begin
        m_exp = c;
        if (bl && ec != c) rexp = "R3";
        rint = ir ? "R2" : "R10";
      end else m_int = c;
    end else begin
      rpc = te ? (ev ? "R11" : (bl && !sl ? "R4" : "R10")) : "R11";
      rspc = rpc; rsr = rpc; rexp = rpc; rint = rpc;
    end
    @(negedge clk);
    check(acc ? "R11" : rpc, "taken", {31'd0, taken}, {31'd0, acc});
    check(rsr, "sr_out", sr_out, m_sr);
    check(rpc, "pc_out", pc_out, m_pc);
    check(acc ? "R5" : rpc, "ssr_out", ssr_out, m_ssr);
    check(rspc, "spc_out", spc_out, m_spc);
    check(acc ? "R5" : rpc, "sgr_out", sgr_out, m_sgr);
    check(rexp, "expevt_out", {20'd0, expevt_out}, {20'd0, m_exp});
    check(rint, "intevt_out", {20'd0, intevt_out}, {20'd0, m_int});
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; take_event = 0; exc_valid = 0; exc_code = 0; irq_req = 0;
    core_sleep = 0; dslot_in = 0; sr_in = 0; pc_in = 0; r15_in = 0; vbr_in = 0;
    irq_vec_valid = 0; irq_vec = 0;
    m_sr = 0; m_pc = 0; m_ssr = 0; m_spc = 0; m_sgr = 0; m_exp = 0; m_int = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "taken", {31'd0, taken}, 32'd0);
    check("R1", "sr_out", sr_out, 32'd0);
    check("R1", "pc_out", pc_out, 32'd0);
    check("R1", "spc_out", spc_out, 32'd0);
    check("R1", "expevt_out", {20'd0, expevt_out}, 32'd0);
    rst = 1'b0;

    // directed corners
    step(1, 1, 12'h1E0, 0, 0, 0, 32'h1000_00F0, 32'h8C00_1000, 32'hAA, 32'h8000_0000, 0, 0); // R3 exempt code
    step(1, 1, 12'h0A0, 1, 0, 0, 32'h1000_0030, 32'h8C00_2000, 32'hBB, 32'h8000_0000, 1, 12'h320); // R3 -> reset
    step(1, 0, 0, 1, 0, 0, 32'h1000_0000, 32'h1234, 32'hCC, 32'h9000_0000, 1, 12'h400); // R4 blocked
    step(1, 0, 0, 1, 1, 0, 32'h1000_0000, 32'h1238, 32'hDD, 32'h9000_0000, 1, 12'h420); // R4 sleep wakes
    step(1, 0, 0, 1, 0, 0, 32'h0000_0080, 32'h2000, 32'hEE, 32'h9000_0000, 0, 12'h440); // R10 no vector
    step(1, 1, 12'h160, 0, 0, 1, 32'h0000_8000, 32'h3000, 32'h11, 32'h9000_0000, 0, 0); // R9 with R6
    step(1, 1, 12'h060, 0, 0, 1, 32'h0000_8000, 32'h3100, 32'h22, 32'h9100_0000, 0, 0); // R6 miss
    step(1, 1, 12'h020, 0, 0, 0, 32'h0000_8000, 32'h3200, 32'h33, 32'h9100_0000, 0, 0); // R7
    step(0, 1, 12'h180, 1, 0, 0, 32'h0000_0000, 32'h3300, 32'h44, 32'h9100_0000, 1, 12'h500); // R11 idle
    step(1, 1, 12'h180, 1, 0, 0, 32'h0000_0000, 32'h3400, 32'h55, 32'h9100_0000, 1, 12'h520); // R2

    for (int i = 0; i < 600; i++) begin
      logic [31:0] sr;
      sr = $urandom;
      if ($urandom % 3 != 0) sr[28] = 1'b0;
      step(($urandom % 5) != 0, ($urandom % 2) == 0, pick_code($urandom),
           ($urandom % 3) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
           sr, $urandom & 32'hFFFF_FFFE, $urandom, $urandom & 32'hFFFF_F000,
           ($urandom % 4) != 0, 12'h200 + 12'(($urandom % 32) * 32));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule